// File: doc/BRIEF.md
# TDM Receive Sampling-Phase Aligner

This block sits at the receive edge of a multi-line TDM port. Each serial input line is oversampled on a clock running at OVS times the bit rate (four by default), which gives quarter-bit phase resolution. A shared frame-sync pulse fixes the bit grid. In every bit period the block picks one sample per line and presents it as a realigned serial bit. By default the pick falls three quarters of the way into the bit. Each line may move its pick later or earlier by half a bit, one bit or two bits. This absorbs board and transceiver skew between lines without any change to the frame logic downstream.

All lines leave the block with the same timing. A single bit strobe marks each new bit, and a frame-first flag marks bit 0 of a frame. Advance is achieved by running every line through the same fixed latency of two bit periods and tapping an earlier point in a per-line sample history. Each line can also take its bits from its own transmit stream (loopback) instead of its pin.

The configuration word and the global delay enable are captured only on the frame-sync pulse. A line's phase therefore never moves inside a frame.

Top module: `tdm_rx_aligner`

## Requirements
- R1: For a line whose step code is 00, the bit output with bit index k of a frame equals that line's selected input in cycle 4k+3, where cycle 0 is the cycle that carries the frame-sync pulse. This holds whatever the line's delay bit is. The result is visible from cycle 4k+12, together with the strobe.
- R2: With the line's delay bit at 1 and the global delay enable at 1, step codes 01, 10 and 11 move the sampling cycle 2, 4 and 8 clocks later than in R1 (half, one and two bits). The output cycle does not change.
- R3: With the line's delay bit at 0, step codes 01, 10 and 11 move the sampling cycle 2, 4 and 8 clocks earlier than in R1. The output cycle does not change.
- R4: While the captured global delay enable is 0, a line whose delay bit is 1 samples exactly as with step code 00.
- R5: A line whose loopback bit is 1 samples its loopback input `lb_i[i]` instead of `pin_i[i]`. The select that applies to a given sample is the one active in the cycle the sample is taken.
- R6: Line i is controlled by `cfg_i[4i+3:4i]`. Bit 3 is loopback, bit 2 is delay direction, and bits 1:0 are the step code.
- R7: After reset, `rx_o`, `stb_o` and `first_o` are 0 and the active configuration is all zero. No strobe appears before the first frame-sync pulse.
- R8: Once a frame-sync pulse has been seen, `stb_o` is high for exactly one cycle in every 4. It is first high in cycle 4 after the pulse. `first_o` is high only together with the strobe that carries bit 0, which is the strobe in cycle 12 after the pulse.
- R9: `cfg_i` and `dly_en_i` are captured at the end of the frame-sync cycle and apply from the next cycle. Changes between pulses have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame-sync pulse, one clock wide, in the first quarter of bit 0 |
| dly_en_i | input | 1 | Global enable for delay-direction offsets |
| cfg_i | input | 4*LANES | Per-line control nibbles {loopback, delay, step[1:0]} |
| pin_i | input | LANES | Serial receive lines |
| lb_i | input | LANES | Per-line loopback source (transmit stream) |
| rx_o | output | LANES | Realigned receive bit per line, valid with stb_o |
| stb_o | output | 1 | One-cycle bit strobe, common to all lines |
| first_o | output | 1 | Marks the strobe that carries bit 0 of a frame |

## Verification
The hardest situation to reach is a configuration write that lands in the middle of a frame. The bench has to show that the old phase and loopback choice stay in force until the next sync pulse, and that a delayed tap can reach samples taken after the nominal point. To get there, the stimulus changes `cfg_i` and `dly_en_i` at cycle 60 of a frame, in every segment. Each input line is driven with fresh random data every quarter bit, so every tap position carries a distinct value and an off-by-one in phase shows up as a mismatch. A cycle-indexed log of the selected inputs predicts each strobe's bits.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;

   // Per-line control nibble; bit order matters for the packed config word.
   typedef struct packed {
      logic       loop;
      logic       dly;
      logic [1:0] step;
   } lane_cfg_t;

   localparam int LANE_CFG_W = $bits(lane_cfg_t);

   // Signed sampling offset in clocks: positive is later, negative earlier.
   function automatic int offset_clk(lane_cfg_t c, logic en, int ovs);
      int mag;
      case (c.step)
         2'd1:    mag = ovs / 2;
         2'd2:    mag = ovs;
         2'd3:    mag = 2 * ovs;
         default: mag = 0;
      endcase
      if (c.dly) begin
         return en ? mag : 0;
      end
      return -mag;
   endfunction

endpackage

// File: rtl/tdm_align_timing.sv
module tdm_align_timing #(
   parameter int OVS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fsync_i,
   output logic smp_stb,
   output logic first_stb
);
   localparam int PW        = $clog2(OVS);
   localparam int SMP_PH    = (3 * OVS) / 4;
   localparam int FIRST_IDX = 2;  // fixed latency of two bits

   logic [PW-1:0] phase_q;
   logic [PW-1:0] cur_ph;
   logic          locked_q;
   logic [1:0]    bitn_q;

   assign cur_ph    = fsync_i ? '0 : phase_q;
   assign smp_stb   = locked_q && (cur_ph == PW'(SMP_PH));
   assign first_stb = smp_stb && (bitn_q == 2'(FIRST_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= '0;
         locked_q <= 1'b0;
         bitn_q   <= '0;
      end else begin
         phase_q <= fsync_i ? PW'(1) : phase_q + PW'(1);
         if (fsync_i) begin
            locked_q <= 1'b1;
            bitn_q   <= '0;
         end else if (smp_stb && bitn_q != 2'd3) begin
            bitn_q <= bitn_q + 2'd1;
         end
      end
   end

   // R8
   sync_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_i |=> !smp_stb);

   // R8
   stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !smp_stb);

endmodule

// File: rtl/tdm_align_lane.sv
module tdm_align_lane
   import tdm_align_pkg::*;
#(
   parameter int OVS         = 4,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_i,
   input  logic      lb_i,
   input  lane_cfg_t cfg,
   input  logic      dly_en,
   input  logic      smp_stb,
   output logic      rx_o
);
   localparam int LAT  = 2 * OVS;
   localparam int HIST = 4 * OVS;
   localparam int IW   = $clog2(HIST + 1);

   logic            in_sel;
   logic [HIST-1:0] hist_q;
   logic [HIST:0]   taps;
   logic [IW-1:0]   tap_idx;
   logic            rx_q;

   generate
      if (LOOPBACK_EN) begin : g_lb
         assign in_sel = cfg.loop ? lb_i : pin_i;

         // R5
         loop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg.loop |=> hist_q[0] == $past(lb_i));
      end else begin : g_nolb
         logic unused_lb;
         assign unused_lb = lb_i ^ cfg.loop;
         assign in_sel    = pin_i;
      end
   endgenerate

   // taps[0] is this cycle's sample, taps[j] the sample j cycles ago.
   assign taps = {hist_q, in_sel};

   always_comb begin
      int off;
      off     = offset_clk(cfg, dly_en, OVS);
      tap_idx = IW'(LAT - off);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         rx_q   <= 1'b0;
      end else begin
         hist_q <= {hist_q[HIST-2:0], in_sel};
         if (smp_stb) rx_q <= taps[tap_idx];
      end
   end

   assign rx_o = rx_q;

   // R4
   gated_no_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dly_en && cfg.dly) |-> (tap_idx >= IW'(LAT)));

endmodule

// File: rtl/tdm_rx_aligner.sv
module tdm_rx_aligner
   import tdm_align_pkg::*;
#(
   parameter int LANES       = 8,
   parameter int OVS         = 4,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fsync_i,
   input  logic                        dly_en_i,
   input  logic [LANE_CFG_W*LANES-1:0] cfg_i,
   input  logic [LANES-1:0]            pin_i,
   input  logic [LANES-1:0]            lb_i,
   output logic [LANES-1:0]            rx_o,
   output logic                        stb_o,
   output logic                        first_o
);
   localparam int CFG_W = LANE_CFG_W * LANES;

   initial begin : elab_chk
      if (OVS < 4 || (OVS & (OVS - 1)) != 0)
         $error("OVS must be a power of two, at least 4");
      if (LANES < 1)
         $error("LANES must be at least 1");
   end

   logic [CFG_W-1:0] cfg_act_q;
   logic             en_act_q;
   logic             smp_stb;
   logic             first_stb;
   logic             stb_q;
   logic             first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_act_q <= '0;
         en_act_q  <= 1'b0;
         stb_q     <= 1'b0;
         first_q   <= 1'b0;
      end else begin
         if (fsync_i) begin
            cfg_act_q <= cfg_i;
            en_act_q  <= dly_en_i;
         end
         stb_q   <= smp_stb;
         first_q <= first_stb;
      end
   end

   tdm_align_timing #(.OVS(OVS)) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .fsync_i   (fsync_i),
      .smp_stb   (smp_stb),
      .first_stb (first_stb)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         tdm_align_lane #(.OVS(OVS), .LOOPBACK_EN(LOOPBACK_EN)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[g]),
            .lb_i    (lb_i[g]),
            .cfg     (lane_cfg_t'(cfg_act_q[LANE_CFG_W*g +: LANE_CFG_W])),
            .dly_en  (en_act_q),
            .smp_stb (smp_stb),
            .rx_o    (rx_o[g])
         );
      end
   endgenerate

   assign stb_o   = stb_q;
   assign first_o = first_q;

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fsync_i |=> ($stable(cfg_act_q) && $stable(en_act_q)));

   // R8
   out_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_o |-> stb_o);

endmodule

// File: tb/tdm_rx_aligner_tb.sv
module tdm_rx_aligner_tb;
   localparam int LANES = 8;
   localparam int OVS   = 4;
   localparam int CW    = 4 * LANES;
   localparam int FRAME = 128;
   localparam int MAXC  = 2048;
   localparam logic [CW-1:0] CFG_A = 32'hD4321765;
   localparam logic [CW-1:0] CFG_B = 32'h0AE39F8B;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fsync_i = 1'b0;
   logic             dly_en_i = 1'b1;
   logic [CW-1:0]    cfg_i = '0;
   logic [LANES-1:0] pin_i = '0;
   logic [LANES-1:0] lb_i = '0;
   logic [LANES-1:0] rx_o;
   logic             stb_o;
   logic             first_o;

   tdm_rx_aligner #(.LANES(LANES), .OVS(OVS)) u_dut (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .dly_en_i(dly_en_i),
      .cfg_i(cfg_i), .pin_i(pin_i), .lb_i(lb_i),
      .rx_o(rx_o), .stb_o(stb_o), .first_o(first_o)
   );

   always #5 clk = ~clk;

   typedef struct {
      bit               stb;
      bit               first;
      logic [LANES-1:0] bits;
      logic [CW-1:0]    cfgw;
      bit               en;
      bit               pend;
   } exp_t;

   exp_t             q[$];
   int               vectors = 0;
   int               miscompares = 0;
   logic [LANES-1:0] ilog [MAXC];
   int               t = 0;
   int               m_ph = 0;
   int               m_cnt = 0;
   bit               m_locked = 0;
   logic [CW-1:0]    m_cfg = '0;
   bit               m_en = 0;

   function automatic int off_of(logic [3:0] nib, bit en);
      int mag;
      mag = (nib[1:0] == 2'd1) ? 2 : (nib[1:0] == 2'd2) ? 4 : (nib[1:0] == 2'd3) ? 8 : 0;
      if (mag == 0) return 0;
      if (nib[2]) return en ? mag : 0;
      return -mag;
   endfunction

   function automatic string tag_of(exp_t e, int i);
      logic [3:0] nib;
      string s;
      nib = e.cfgw[4*i +: 4];
      if (nib[3]) s = "R5";
      else if (nib[1:0] == 2'd0) s = "R1";
      else if (nib[2] && !e.en) s = "R4";
      else if (nib[2]) s = "R2";
      else s = "R3";
      s = {s, " R6"};
      if (e.pend) s = {s, " R9"};
      return s;
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   // Driver: drives one cycle and pushes the expected result of that cycle.
   task automatic step(bit fs);
      exp_t e;
      logic [LANES-1:0] pv, lv, sel;
      int ph;
      @(negedge clk);
      pv = LANES'($urandom);
      lv = LANES'($urandom);
      fsync_i = fs;
      pin_i   = pv;
      lb_i    = lv;
      for (int i = 0; i < LANES; i++) sel[i] = m_cfg[4*i+3] ? lv[i] : pv[i];
      ilog[t] = sel;
      ph = fs ? 0 : m_ph;
      e.stb   = m_locked && (ph == 3);
      e.first = e.stb && (m_cnt == 2);
      e.cfgw  = m_cfg;
      e.en    = m_en;
      e.pend  = (cfg_i != m_cfg) || (dly_en_i != m_en);
      for (int i = 0; i < LANES; i++) begin
         int c;
         c = t - 8 + off_of(m_cfg[4*i +: 4], m_en);
         e.bits[i] = (c >= 0) ? ilog[c][i] : 1'b0;
      end
      q.push_back(e);
      m_ph = fs ? 1 : (ph + 1) % 4;
      if (fs) begin
         m_locked = 1;
         m_cnt    = 0;
         m_cfg    = cfg_i;
         m_en     = dly_en_i;
      end else if (e.stb && m_cnt < 3) begin
         m_cnt++;
      end
      t++;
   endtask

   // Monitor: compares each cycle's outputs against the queued expectation.
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         vectors++;
         if (stb_o !== e.stb || first_o !== e.first) begin
            miscompares++;
            $display("FAIL R8 R7 strobe/first: got %b/%b expected %b/%b", stb_o, first_o, e.stb, e.first);
         end
         if (e.stb) begin
            for (int i = 0; i < LANES; i++) begin
               vectors++;
               if (rx_o[i] !== e.bits[i]) begin
                  miscompares++;
                  $display("FAIL %s line %0d: got %b expected %b", tag_of(e, i), i, rx_o[i], e.bits[i]);
               end
            end
         end
      end
   end

   task automatic set_seg(int n);
      if (n < 3)       begin cfg_i = '0;    dly_en_i = 1'b1; end
      else if (n < 6)  begin cfg_i = CFG_A; dly_en_i = 1'b1; end
      else if (n < 9)  begin cfg_i = CFG_A; dly_en_i = 1'b0; end
      else if (n < 11) begin cfg_i = CFG_B; dly_en_i = 1'b1; end
      else             begin cfg_i = CFG_A; dly_en_i = 1'b1; end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R7: reset state of the outputs
      vectors++;
      if (rx_o !== '0 || stb_o !== 1'b0 || first_o !== 1'b0) begin
         miscompares++;
         $display("FAIL R7 reset: got rx=%h stb=%b first=%b expected 0/0/0", rx_o, stb_o, first_o);
      end
      set_seg(0);
      // R7: no strobes before the first frame-sync
      repeat (20) step(1'b0);
      for (int n = 0; n < 13; n++) begin
         for (int k = 0; k < FRAME; k++) begin
            // R9: configuration written mid-frame
            if (k == 60) set_seg(n + 1);
            step(k == 0);
         end
      end
      repeat (3) step(1'b0);
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

endmodule